// File: doc/BRIEF.md
# Permutation-Rank Bit Regenerator

When a configuration chain is loaded, each lookup table (LUT) is stored without a few of its truth-table bits. The missing bits are not lost. They are carried by the order in which the next LUT in the chain lists its inputs. This block reads the K input-select codes of that next LUT and rebuilds the missing bits of the current one. Each code is a 6-bit routing choice.

For each position i, the block forms a digit d_i. The digit is the number of later positions whose select code is strictly smaller than the code at position i. Together the digits form the factorial-base rank of the input ordering. The block compares every pair of codes, sums each row of comparison results into a digit, and packs the digits into floor(log2(K!)) output bits. One copy serves a whole device, so speed is not a concern. The output is registered once, and the block has a synchronous active-high reset.

The packing depends on K:
- When the plain low-order digit bits are enough (K up to 5), the output is a fixed concatenation of those bits.
- For larger K, the output is the low bits of the weighted rank.

Top module: `perm_rank_regen`

## Requirements
- R1: The output `regen_bits` is floor(log2(K!)) bits wide: 4 bits for K=4, 6 bits for K=5 and 9 bits for K=6.
- R2: Digit d_i counts the later positions whose code is strictly smaller than code i. Position i is the select field `sel_codes[i*6 +: 6]`. For K up to 5 the output is a concatenation with d0 at the most significant end:
  - for K=4 the output is {d0[1:0], d1[0], d2[0]};
  - for K=5 the output is {d0[1:0], d1[1:0], d2[0], d3[0]}.
- R3: For K of 6 or more, the output is the low floor(log2(K!)) bits of the rank, where the rank is the sum over i of d_i*(K-1-i)!.
- R4: The output changes only at a rising clock edge. It shows the result for the codes sampled at that edge, so there is one cycle of latency. While the codes are held, the output holds.
- R5: While `rst` is high at a rising edge, the output is cleared to zero at that edge. The codes present at that edge have no effect.
- R6: Equal codes are never counted against each other, so the earlier of two equal positions ranks lower. When all codes are equal, the output is zero. For K=4, the codes (5,5,2,2) give 8.
- R7: Over all K! orderings of distinct codes, every one of the 2^floor(log2(K!)) output values appears.
- R8: Comparisons use all 6 bits of each code, and only the relative order of the codes matters. For K=4, the codes (63,0,62,1) give 13 and the codes (32,31,0,33) give 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_codes | input | K*SEL_W | Select codes of the next LUT; position i occupies bits [i*SEL_W +: SEL_W] |
| regen_bits | output | floor(log2(K!)) | Regenerated configuration bits, registered |

## Verification
Two properties cannot be shown with a handful of hand-picked orderings. The first is that every output value is reachable. The second is that the digit counting is correct for all orderings. The stimulus therefore runs every ordering, for K of 4, 5 and 6. Each ordering is built by decoding a loop index as a factorial-base number: each position takes the e-th smallest code that is still unused. This gives the expected digits directly, without counting comparisons.

A code-width fault would stay hidden with small codes. Ties are not orderings at all. Both are reached only by directed vectors that use codes near the 32 boundary and codes that repeat.

// File: rtl/prb_pkg.sv
package prb_pkg;

  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  function automatic int flog2(input int x);
    int b;
    b = 0;
    while ((1 << (b + 1)) <= x) b++;
    return b;
  endfunction

  // number of bits regenerated for a K-input LUT
  function automatic int pk_of(input int k);
    return flog2(fact(k));
  endfunction

  // bits obtainable by concatenating whole low-order digit bits
  function automatic int concat_width(input int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += flog2(k - i);
    return s;
  endfunction

endpackage

// File: rtl/prb_order_cmp.sv
module prb_order_cmp #(
  parameter int K     = 4,
  parameter int SEL_W = 6
) (
  input  logic [K*SEL_W-1:0] sel_codes,
  output logic [K*K-1:0]     outranks
);
  // outranks[i*K+j] set when a later position j holds a smaller code than i
  for (genvar gi = 0; gi < K; gi++) begin : g_row
    for (genvar gj = 0; gj < K; gj++) begin : g_col
      if (gj > gi) begin : g_cmp
        assign outranks[gi*K+gj] =
          sel_codes[gj*SEL_W +: SEL_W] < sel_codes[gi*SEL_W +: SEL_W];
      end else begin : g_none
        assign outranks[gi*K+gj] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/prb_rank_count.sv
module prb_rank_count #(
  parameter int K  = 4,
  parameter int DW = 2
) (
  input  logic [K*K-1:0]  outranks,
  output logic [K*DW-1:0] digits
);
  for (genvar gi = 0; gi < K; gi++) begin : g_digit
    logic [DW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = 0; j < K; j++) cnt = cnt + DW'(outranks[gi*K+j]);
    end
    assign digits[gi*DW +: DW] = cnt;
  end
endmodule

// File: rtl/prb_bit_pack.sv
module prb_bit_pack
  import prb_pkg::*;
#(
  parameter int K  = 4,
  parameter int DW = 2,
  parameter int PK = 4
) (
  input  logic [K*DW-1:0] digits,
  output logic [PK-1:0]   bits_out
);
  localparam bit USE_CONCAT = (concat_width(K) == PK);

  if (USE_CONCAT) begin : g_concat
    // d0 occupies the most significant end
    always_comb begin
      int off;
      off      = PK;
      bits_out = '0;
      for (int i = 0; i < K; i++) begin
        off      = off - flog2(K - i);
        bits_out = bits_out | PK'((int'(digits[i*DW +: DW]) &
                                   ((1 << flog2(K - i)) - 1)) << off);
      end
    end
  end else begin : g_rank
    // modular accumulation keeps only the low PK bits of the rank
    always_comb begin
      bits_out = '0;
      for (int i = 0; i < K; i++)
        bits_out = bits_out + PK'(int'(digits[i*DW +: DW]) * fact(K - 1 - i));
    end
  end
endmodule

// File: rtl/perm_rank_regen.sv
module perm_rank_regen
  import prb_pkg::*;
#(
  parameter int K     = 4,
  parameter int SEL_W = 6,
  localparam int PK   = pk_of(K)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [K*SEL_W-1:0] sel_codes,
  output logic [PK-1:0]      regen_bits
);
  localparam int DW = $clog2(K);

  logic [K*K-1:0]  outranks;
  logic [K*DW-1:0] digits;
  logic [PK-1:0]   next_bits;

  prb_order_cmp #(.K(K), .SEL_W(SEL_W)) u_cmp (
    .sel_codes (sel_codes),
    .outranks  (outranks)
  );

  prb_rank_count #(.K(K), .DW(DW)) u_count (
    .outranks (outranks),
    .digits   (digits)
  );

  prb_bit_pack #(.K(K), .DW(DW), .PK(PK)) u_pack (
    .digits   (digits),
    .bits_out (next_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) regen_bits <= '0;
    else     regen_bits <= next_bits;
  end
endmodule

// File: rtl/perm_rank_regen_chk.sv
module perm_rank_regen_chk #(
  parameter int K     = 4,
  parameter int SEL_W = 6,
  parameter int PK    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [K*SEL_W-1:0] sel_codes,
  input logic [PK-1:0]      regen_bits
);
  logic all_same;
  logic ascending;
  logic rst_q;

  always_comb begin
    all_same  = 1'b1;
    ascending = 1'b1;
    for (int i = 0; i + 1 < K; i++) begin
      if (sel_codes[i*SEL_W +: SEL_W] != sel_codes[(i+1)*SEL_W +: SEL_W])
        all_same = 1'b0;
      if (!(sel_codes[i*SEL_W +: SEL_W] < sel_codes[(i+1)*SEL_W +: SEL_W]))
        ascending = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R5
    if (rst_q) reset_zero_chk: assert (regen_bits == '0);
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(sel_codes)) |=> $stable(regen_bits));

  // R6
  tie_zero_chk: assert property (@(posedge clk) disable iff (rst)
    all_same |=> (regen_bits == '0));

  // R2
  sorted_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ascending |=> (regen_bits == '0));
endmodule

bind perm_rank_regen perm_rank_regen_chk #(.K(K), .SEL_W(SEL_W), .PK(PK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_codes  (sel_codes),
  .regen_bits (regen_bits)
);

// File: tb/test_perm_rank_regen.sv
module test_perm_rank_regen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] sel4 = '0;
  logic [29:0] sel5 = '0;
  logic [35:0] sel6 = '0;
  logic [3:0]  out4;
  logic [5:0]  out5;
  logic [8:0]  out6;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perm_rank_regen #(.K(4)) i_perm_rank_regen (
    .clk(clk), .rst(rst), .sel_codes(sel4), .regen_bits(out4));
  perm_rank_regen #(.K(5)) i_perm_rank_regen_k5 (
    .clk(clk), .rst(rst), .sel_codes(sel5), .regen_bits(out5));
  perm_rank_regen #(.K(6)) i_perm_rank_regen_k6 (
    .clk(clk), .rst(rst), .sel_codes(sel6), .regen_bits(out6));

  // {code3, code2, code1, code0, expected} for K=4
  localparam logic [27:0] VEC [7] = '{
    {6'd3,  6'd2,  6'd1,  6'd0,  4'd0},
    {6'd0,  6'd1,  6'd2,  6'd3,  4'd13},
    {6'd15, 6'd5,  6'd20, 6'd10, 4'd4},
    {6'd1,  6'd62, 6'd0,  6'd63, 4'd13},
    {6'd33, 6'd0,  6'd31, 6'd32, 4'd10},
    {6'd2,  6'd2,  6'd5,  6'd5,  4'd8},
    {6'd9,  6'd9,  6'd9,  6'd9,  4'd0}
  };
  string vec_req [7] = '{"R2 identity", "R2 descending", "R2 mixed",
                         "R8 extremes", "R8 bit5", "R6 pairs", "R6 all equal"};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int bfact(input int n);
    int r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  // ordering number n decoded into factorial digits; code of value v is v*7+3
  task automatic build(input int k, input int n, output logic [47:0] sel, output int exp);
    bit used [8];
    int rem, e, pos, off, b, v;
    rem = n; sel = '0; exp = 0;
    off = (k == 4) ? 4 : 6;
    for (int i = 0; i < 8; i++) used[i] = 0;
    for (int i = 0; i < k; i++) begin
      e = rem / bfact(k - 1 - i);
      rem = rem % bfact(k - 1 - i);
      pos = 0; v = 0;
      for (int c = 0; c < k; c++)
        if (!used[c]) begin
          if (pos == e) v = c;
          pos++;
        end
      used[v] = 1;
      sel[i*6 +: 6] = 6'(v * 7 + 3);
      b = (k - i >= 4) ? 2 : (k - i >= 2) ? 1 : 0;
      off = off - b;
      exp = exp | ((e & ((1 << b) - 1)) << off);
    end
    if (k == 6) exp = n % 512;
  endtask

  task automatic run_all(input int k);
    bit seen [512];
    logic [47:0] sel;
    logic [31:0] got;
    int exp, hits, width;
    width = (k == 4) ? 4 : (k == 5) ? 6 : 9;
    for (int i = 0; i < 512; i++) seen[i] = 0;
    for (int n = 0; n < bfact(k); n++) begin
      build(k, n, sel, exp);
      @(negedge clk);
      case (k)
        4: sel4 = sel[23:0];
        5: sel5 = sel[29:0];
        default: sel6 = sel[35:0];
      endcase
      @(posedge clk);
      @(negedge clk);
      got = (k == 4) ? 32'(out4) : (k == 5) ? 32'(out5) : 32'(out6);
      check((k == 6) ? "R3 rank" : "R2 digits", got, exp);
      seen[got[8:0]] = 1;
    end
    hits = 0;
    for (int i = 0; i < 512; i++) if (seen[i]) hits++;
    check("R7 all values reached", hits, 1 << width);
  endtask

  initial begin
    // R5: reset with nonzero codes present
    sel4 = {6'd0, 6'd1, 6'd2, 6'd3};
    sel6 = {6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset k4", out4, 0);
    check("R5 reset k5", out5, 0);
    check("R5 reset k6", out6, 0);
    // R1
    check("R1 width k4", $bits(out4), 4);
    check("R1 width k5", $bits(out5), 6);
    check("R1 width k6", $bits(out6), 9);
    rst = 1'b0;

    for (int t = 0; t < 7; t++) begin
      @(negedge clk);
      sel4 = VEC[t][27:4];
      @(posedge clk);
      @(negedge clk);
      check(vec_req[t], out4, VEC[t][3:0]);
    end

    // R4: one cycle of latency, no path from inputs to output
    @(negedge clk);
    sel4 = {6'd3, 6'd2, 6'd1, 6'd0};
    @(posedge clk);
    @(negedge clk);
    check("R4 before", out4, 0);
    sel4 = {6'd0, 6'd1, 6'd2, 6'd3};
    #1;
    check("R4 no change before edge", out4, 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 after edge", out4, 13);
    repeat (2) @(negedge clk);
    check("R4 held", out4, 13);

    // R5: reset in mid-run clears despite nonzero result
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5 mid reset", out4, 0);
    rst = 1'b0;

    run_all(4);
    run_all(5);
    run_all(6);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule